// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is a free-running timer with a single output compare channel. A counter of twice the bus width advances once every `PRE_DIV` cycles in which the internal clock enable `tick_i` is high. Software loads a compare value as two bytes through a small register port. When the counter steps off the compare value, the block does three things:

- it raises a compare flag;
- it copies a programmed level onto the compare output pin;
- it can request an interrupt.

The port has four registers:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 is the level for the pin, bit 1 is the interrupt enable |
| 1 | status | bit 0 is the compare flag, read-only |
| 2 | compare high | upper byte of the compare value |
| 3 | compare low | lower byte of the compare value |

Loading the compare value is made safe against a torn update. Writing the high byte inhibits all matching until the low byte is written.

The flag can only be cleared by a deliberate two-step sequence. Software first reads the status register while the flag is set, then reads or writes the compare low byte.

Top module: `tmr_ocmp_top`

## Requirements
- R1: After reset the counter starts at `CNT_INIT` and increments once per `PRE_DIV` cycles with `tick_i` high; cycles with `tick_i` low do not advance it. A compare value C is matched on the clock edge at which the counter moves from C to C+1.
- R2: The compare high byte is at address 2 and the low byte at address 3, both readable. Their contents are kept through reset.
- R3: A write to address 2 blocks every match until address 3 is written, and the write to address 3 re-enables matching.
- R4: An enabled match sets the compare flag, which reads back as bit 0 of the status register (address 1).
- R5: A read or write of address 3 clears the flag only if a status read made while the flag was set came before it. Without that status read, such an access leaves the flag set.
- R6: A status read arms the clear only once: the next access to address 3 consumes it. A status read made while the flag is clear does not arm.
- R7: On every match the control bit 0 value is copied to `ocmp_o`, even when the flag is already set.
- R8: `irq_o` is high exactly while the flag is set and control bit 1 is 1. Clearing the enable hides the flag without clearing it.
- R9: Reset does the following: it clears the flag, the arm state and the control bits; it drives `ocmp_o` and `irq_o` low; it releases the compare inhibit.
- R10: When a match and an armed clearing access to address 3 fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal clock enable feeding the prescaler |
| bus_rd_i | input | 1 | Register read strobe, one cycle per access |
| bus_wr_i | input | 1 | Register write strobe, one cycle per access |
| bus_addr_i | input | 2 | Register address (0 control, 1 status, 2 compare high, 3 compare low) |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data, valid in the cycle of `bus_rd_i` |
| ocmp_o | output | 1 | Compare output pin latch |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on these properties of the bus:

- a read and a write never occur in the same cycle;
- each strobe lasts exactly one cycle;
- address and data are stable while a strobe is high.

The priority and arm rules are defined only under these conditions. The bench drives the bus through single-access tasks that raise one strobe for one cycle, change the address and data only at the falling edge, and always write the compare high byte before the low byte. It checks timing against its own count of prescaled ticks. For the same-edge case it aims a low-byte read at the exact cycle in which its count predicts a match.

// File: rtl/tmr_ocmp_pkg.sv
package tmr_ocmp_pkg;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_STAT = 2'd1,
      ADDR_CMPH = 2'd2,
      ADDR_CMPL = 2'd3
   } ocmp_addr_e;

   localparam int CTRL_LVL_BIT  = 0;
   localparam int CTRL_IE_BIT   = 1;
   localparam int STAT_FLAG_BIT = 0;

   typedef struct packed {
      logic wr_ctrl;
      logic rd_stat;
      logic wr_hi;
      logic wr_lo;
      logic acc_lo;
   } bus_dec_t;

endpackage

// File: rtl/tmr_ocmp_prescale.sv
module tmr_ocmp_prescale #(
   parameter int PRE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic adv_o
);
   localparam int  DW       = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
   localparam bit  IS_POW2  = ((PRE_DIV & (PRE_DIV - 1)) == 0);

   generate
      if (PRE_DIV < 2) begin : g_bad_div
         $error("tmr_ocmp_prescale: PRE_DIV must be 2 or more");
      end

      if (IS_POW2) begin : g_pow2
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      div_q <= '0;
            else if (tick_i) div_q <= div_q + 1'b1;
         end
         assign adv_o = tick_i && (&div_q);
      end else begin : g_mod
         localparam logic [DW-1:0] LAST = DW'(PRE_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      div_q <= '0;
            else if (tick_i) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
         end
         assign adv_o = tick_i && (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/tmr_ocmp_counter.sv
module tmr_ocmp_counter #(
   parameter int CNT_W    = 16,
   parameter int CNT_INIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] START = CNT_W'(CNT_INIT);

   generate
      if (CNT_W < 4) begin : g_bad_w
         $error("tmr_ocmp_counter: CNT_W must be 4 or more");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_o <= START;
      else if (adv_i) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/tmr_ocmp_cmpreg.sv
module tmr_ocmp_cmpreg #(
   parameter int BUS_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_hi_i,
   input  logic               wr_lo_i,
   input  logic [BUS_W-1:0]   wdata_i,
   output logic [2*BUS_W-1:0] cmp_o,
   output logic               inh_o
);
   logic [BUS_W-1:0] hi_q;
   logic [BUS_W-1:0] lo_q;

   // Compare bytes hold their contents through reset.
   always_ff @(posedge clk) begin
      if (wr_hi_i) hi_q <= wdata_i;
      if (wr_lo_i) lo_q <= wdata_i;
   end

   // High-byte write blocks matching until the low byte follows.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       inh_o <= 1'b0;
      else if (wr_hi_i) inh_o <= 1'b1;
      else if (wr_lo_i) inh_o <= 1'b0;
   end

   assign cmp_o = {hi_q, lo_q};
endmodule

// File: rtl/tmr_ocmp_flag.sv
module tmr_ocmp_flag #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             inh_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             rd_stat_i,
   input  logic             acc_lo_i,
   input  logic             lvl_i,
   output logic             flag_o,
   output logic             arm_o,
   output logic             pin_o
);
   logic hit;

   assign hit = adv_i && !inh_i && (cnt_i == cmp_i);

   // Setting has priority so a match is never lost to a clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flag_o <= 1'b0;
      else if (hit)                   flag_o <= 1'b1;
      else if (acc_lo_i && arm_o)     flag_o <= 1'b0;
   end

   // One status read with the flag up permits one clearing access.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     arm_o <= 1'b0;
      else if (acc_lo_i)              arm_o <= 1'b0;
      else if (rd_stat_i && flag_o)   arm_o <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pin_o <= 1'b0;
      else if (hit) pin_o <= lvl_i;
   end
endmodule

// File: rtl/tmr_ocmp_top.sv
module tmr_ocmp_top
   import tmr_ocmp_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int PRE_DIV  = 4,
   parameter int CNT_INIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             bus_rd_i,
   input  logic             bus_wr_i,
   input  logic [1:0]       bus_addr_i,
   input  logic [BUS_W-1:0] bus_wdata_i,
   output logic [BUS_W-1:0] bus_rdata_o,
   output logic             ocmp_o,
   output logic             irq_o
);
   localparam int CNT_W = 2 * BUS_W;

   generate
      if (BUS_W < 2) begin : g_bad_bus
         $error("tmr_ocmp_top: BUS_W must be 2 or more");
      end
   endgenerate

   bus_dec_t         dec;
   logic             adv;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmp;
   logic             inh;
   logic             flag;
   logic             arm;
   logic             ctrl_lvl;
   logic             ctrl_ie;

   always_comb begin
      dec         = '0;
      dec.wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_CTRL);
      dec.rd_stat = bus_rd_i && (bus_addr_i == ADDR_STAT);
      dec.wr_hi   = bus_wr_i && (bus_addr_i == ADDR_CMPH);
      dec.wr_lo   = bus_wr_i && (bus_addr_i == ADDR_CMPL);
      dec.acc_lo  = (bus_rd_i || bus_wr_i) && (bus_addr_i == ADDR_CMPL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_lvl <= 1'b0;
         ctrl_ie  <= 1'b0;
      end else if (dec.wr_ctrl) begin
         ctrl_lvl <= bus_wdata_i[CTRL_LVL_BIT];
         ctrl_ie  <= bus_wdata_i[CTRL_IE_BIT];
      end
   end

   tmr_ocmp_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .adv_o  (adv)
   );

   tmr_ocmp_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (adv),
      .cnt_o (cnt)
   );

   tmr_ocmp_cmpreg #(.BUS_W(BUS_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi_i (dec.wr_hi),
      .wr_lo_i (dec.wr_lo),
      .wdata_i (bus_wdata_i),
      .cmp_o   (cmp),
      .inh_o   (inh)
   );

   tmr_ocmp_flag #(.CNT_W(CNT_W)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .inh_i     (inh),
      .cnt_i     (cnt),
      .cmp_i     (cmp),
      .rd_stat_i (dec.rd_stat),
      .acc_lo_i  (dec.acc_lo),
      .lvl_i     (ctrl_lvl),
      .flag_o    (flag),
      .arm_o     (arm),
      .pin_o     (ocmp_o)
   );

   assign irq_o = flag && ctrl_ie;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_rd_i) begin
         case (bus_addr_i)
            ADDR_CTRL: begin
               bus_rdata_o[CTRL_LVL_BIT] = ctrl_lvl;
               bus_rdata_o[CTRL_IE_BIT]  = ctrl_ie;
            end
            ADDR_STAT: bus_rdata_o[STAT_FLAG_BIT] = flag;
            ADDR_CMPH: bus_rdata_o = cmp[CNT_W-1:BUS_W];
            default:   bus_rdata_o = cmp[BUS_W-1:0];
         endcase
      end
   end
endmodule

// File: rtl/tmr_ocmp_chk.sv
module tmr_ocmp_chk #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adv,
   input logic             inh,
   input logic             flag,
   input logic             arm,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic             bus_rd_i,
   input logic             bus_wr_i,
   input logic [1:0]       bus_addr_i,
   input logic [BUS_W-1:0] bus_wdata_i,
   input logic             ocmp_o,
   input logic             irq_o
);
   logic acc_lo, wr_hi, wr_ctrl;
   assign acc_lo  = (bus_rd_i || bus_wr_i) && (bus_addr_i == 2'd3);
   assign wr_hi   = bus_wr_i && (bus_addr_i == 2'd2);
   assign wr_ctrl = bus_wr_i && (bus_addr_i == 2'd0);

   assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt));
   assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
   assert_inh_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> inh);
   assert_no_set_inhibited_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> !$past(inh));
   assert_set_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(adv) && ($past(cnt) == $past(cmp))));
   assert_flag_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !acc_lo) |=> flag);
   assert_clear_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> ($past(arm) && $past(acc_lo)));
   assert_arm_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_lo |=> !arm);
   assert_pin_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ocmp_o) |-> ($past(adv) && !$past(inh)));
   assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata_i[1]) |=> !irq_o);
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !inh && (cnt == cmp)) |=> flag);
   assert_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd_i && bus_wr_i));
endmodule

bind tmr_ocmp_top tmr_ocmp_chk #(.CNT_W(2 * BUS_W), .BUS_W(BUS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .adv         (adv),
   .inh         (inh),
   .flag        (flag),
   .arm         (arm),
   .cnt         (cnt),
   .cmp         (cmp),
   .bus_rd_i    (bus_rd_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .ocmp_o      (ocmp_o),
   .irq_o       (irq_o)
);

// File: tb/tmr_ocmp_top_tb_top.sv
`timescale 1ns/1ps
module tmr_ocmp_top_tb_top;
   localparam int BW = 4;
   localparam int PD = 4;
   localparam int NV = 256;
   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_HI = 2'd2, A_LO = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic tick_toggle = 1'b0;
   logic rd = 1'b0;
   logic wr = 1'b0;
   logic [1:0] addr = '0;
   logic [BW-1:0] wdata = '0;
   logic [BW-1:0] rdata;
   logic ocmp, irq;

   int checks = 0;
   int errors = 0;
   int m_div = 0;
   int m_cnt = 0;

   always #4 clk = ~clk;

   always @(negedge clk) tick <= tick_toggle ? ~tick : 1'b1;

   // Independent count of prescaled ticks (R1).
   always @(posedge clk) begin
      if (!rst_n) begin
         m_div <= 0;
         m_cnt <= 0;
      end else if (tick) begin
         if (m_div == PD - 1) begin
            m_div <= 0;
            m_cnt <= (m_cnt + 1) % NV;
         end else begin
            m_div <= m_div + 1;
         end
      end
   end

   tmr_ocmp_top #(.BUS_W(BW), .PRE_DIV(PD), .CNT_INIT(0)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .bus_rd_i    (rd),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .ocmp_o      (ocmp),
      .irq_o       (irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input int d);
      @(negedge clk);
      addr = a; wdata = BW'(d); wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output int d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = int'(rdata);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic set_cmp(input int c);
      bus_wr(A_HI, (c >> BW) & 15);
      bus_wr(A_LO, c & 15);
   endtask

   task automatic wait_at(input int c, input int d);
      do @(negedge clk); while (!(m_cnt == c && m_div == d));
   endtask

   task automatic pulse_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int d;
      int seen;
      int prev;
      repeat (3) @(negedge clk);
      check("R9 reset irq low", irq, 0);
      check("R9 reset pin low", ocmp, 0);
      rst_n = 1'b1;
      bus_rd(A_CTRL, d); check("R9 control cleared", d, 0);
      bus_rd(A_STAT, d); check("R9 flag cleared", d, 0);

      // R2: byte placement and retention through reset
      bus_wr(A_HI, 4'hA);
      bus_wr(A_LO, 4'h5);
      bus_rd(A_HI, d); check("R2 high byte readback", d, 10);
      bus_rd(A_LO, d); check("R2 low byte readback", d, 5);
      pulse_reset();
      bus_rd(A_HI, d); check("R2 high byte kept by reset", d, 10);
      bus_rd(A_LO, d); check("R2 low byte kept by reset", d, 5);

      // R1/R4/R7/R5: sweep of compare values with alternating level
      for (int k = 0; k < 16; k++) begin
         int c;
         int lvl;
         c = k * 17;
         lvl = k % 2;
         bus_wr(A_CTRL, 2 | lvl);
         set_cmp(c);
         wait_at(c, PD - 1);
         check("R1 no flag one cycle before the step", irq, 0);
         @(negedge clk);
         check("R4 flag set on step past compare", irq, 1);
         check("R7 level copied to pin", ocmp, lvl);
         bus_rd(A_STAT, d); check("R4 status bit0", d & 1, 1);
         bus_rd(A_LO, d);   check("R5 armed low read clears", irq, 0);
      end

      // R1: gated tick stretches the prescale
      tick_toggle = 1'b1;
      set_cmp(8'h20);
      wait_at(8'h20, PD - 1);
      check("R1 gated tick no early match", irq, 0);
      do @(negedge clk); while (m_cnt != 8'h21);
      check("R1 gated tick match", irq, 1);
      tick_toggle = 1'b0;
      bus_rd(A_STAT, d);
      bus_rd(A_LO, d);
      check("R5 clear after gated run", irq, 0);

      // R3: inhibit between high and low writes
      bus_wr(A_CTRL, 3);
      bus_wr(A_HI, 4);
      seen = 0;
      repeat (1100) begin
         @(negedge clk);
         if (irq) seen = 1;
      end
      check("R3 no match while inhibited", seen, 0);
      bus_wr(A_LO, 0);
      wait_at(8'h40, PD - 1);
      check("R3 still clear before step", irq, 0);
      @(negedge clk);
      check("R3 match after low write", irq, 1);

      // R5: low access without status read keeps flag
      bus_rd(A_LO, d); check("R5 unarmed low read keeps flag", irq, 1);
      bus_wr(A_LO, 0); check("R5 unarmed low write keeps flag", irq, 1);

      // R7: pin updates although flag already set
      bus_wr(A_CTRL, 2);
      wait_at(8'h40, PD - 1);
      check("R7 pin before match", ocmp, 1);
      @(negedge clk);
      check("R7 pin updated with flag already set", ocmp, 0);
      check("R7 flag remains set", irq, 1);

      // R6: arm consumed, and no arming while flag clear
      bus_rd(A_STAT, d);
      bus_rd(A_LO, d);   check("R5 arm then clear", irq, 0);
      bus_rd(A_STAT, d); check("R6 status read with flag clear", d & 1, 0);
      wait_at(8'h40, PD - 1);
      @(negedge clk);
      check("R6 flag set again", irq, 1);
      bus_rd(A_LO, d);   check("R6 status read while clear did not arm", irq, 1);
      bus_rd(A_STAT, d);
      bus_rd(A_LO, d);   check("R5 clear with fresh arm", irq, 0);
      wait_at(8'h40, PD - 1);
      @(negedge clk);
      bus_rd(A_LO, d);   check("R6 arm used once", irq, 1);

      // R10: set and armed clear on the same edge
      bus_rd(A_STAT, d);
      wait_at(8'h40, PD - 1);
      addr = A_LO; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      check("R10 set wins over clear", irq, 1);

      // R8: interrupt enable gating
      bus_wr(A_CTRL, 0); check("R8 irq hidden by enable", irq, 0);
      bus_rd(A_STAT, d); check("R8 flag still set", d & 1, 1);
      bus_wr(A_CTRL, 3); check("R8 irq back with enable", irq, 1);
      bus_rd(A_LO, d);   check("R8 irq drops on clear", irq, 0);

      // R9: reset mid-operation releases the inhibit
      wait_at(8'h40, PD - 1);
      @(negedge clk);
      prev = ocmp;
      check("R9 pin high before reset", prev, 1);
      bus_wr(A_HI, 4);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R9 irq low in reset", irq, 0);
      check("R9 pin low in reset", ocmp, 0);
      rst_n = 1'b1;
      bus_rd(A_CTRL, d); check("R9 control cleared", d, 0);
      bus_rd(A_STAT, d); check("R9 flag cleared", d, 0);
      bus_wr(A_CTRL, 2);
      wait_at(8'h40, PD - 1);
      check("R9 no flag before step", irq, 0);
      @(negedge clk);
      check("R9 inhibit released by reset", irq, 1);

      finish_run();
   end
endmodule